// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block decides, for a small 8-bit processor core, when the core should leave its current program flow to service one of five request sources and where it should go. The sources are two external-event flags, two timer-overflow flags and a serial request, which is the OR of a receive-done level and a transmit-done level that the serial port drives. The core writes an enable register and a priority register through a one-byte write port. At each instruction boundary the core pulses `insnDone`. The controller then either stays quiet or issues a one-cycle `takeIrq` pulse together with the 16-bit handler address.

Two levels of service are tracked, high and low. A high-level request can preempt a low-level handler. A low-level request waits until no handler is active. Nothing preempts a high-level handler. Within one level, a fixed polling order settles ties. Taking an external or timer source clears its flag in hardware. The serial request is never cleared by the controller: it keeps firing until the serial port drops both of its levels. The core pulses `retStrobe` when it executes a return from interrupt. This closes the innermost active level.

Top module: `irqCtrl`

## Requirements
- R1: After reset, `takeIrq` is 0, `inSvc` is 00, all flags are 0, and every enable bit is 0. A pending flag produces no vector until software enables it.
- R2: With `cfgSel`=0 a write loads the enable register. Bit 0 enables external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1 and bit 4 serial. Bit 7 is a global gate. A source is taken only when both its own bit and bit 7 are 1.
- R3: Requests are evaluated only on a cycle where `insnDone` is 1. When such an evaluation finds a winner, `takeIrq` is 1 for exactly the following cycle, and `vecAddr` is valid in that same cycle.
- R4: Among pending requests of the same level, the winner follows the order external 0, timer 0, external 1, timer 1, serial.
- R5: An enabled high-level request always wins over an enabled low-level request, whatever their polling order.
- R6: While `inSvc[1]` (high level active) is 1, no request is taken, including another high-level one.
- R7: A high-level request is taken while only the low level is active, and `inSvc` then becomes 11.
- R8: A low-level request is taken only when `inSvc` is 00. Taking it sets `inSvc[0]`. Taking a high-level request sets `inSvc[1]`.
- R9: The handler addresses are 0003h for external 0, 000Bh for timer 0, 0013h for external 1, 001Bh for timer 1 and 0023h for serial.
- R10: The `hwEvt` pulses set the four flags. Bit 0 sets external 0, bit 1 timer 0, bit 2 external 1 and bit 3 timer 1. A flag stays set until its source is taken, and is then 0 in the cycle where `takeIrq` is 1. The serial request follows `serRx | serTx` and re-triggers after each return while either level is high.
- R11: A `retStrobe` clears `inSvc[1]` if it is set, and otherwise clears `inSvc[0]`.
- R12: With `cfgSel`=1 a write loads the priority register. It uses the same bit-per-source layout as the enable register, bits 0 to 4, and a 1 selects the high level. Bits 7 to 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | 0 selects enable register, 1 selects priority register |
| cfgWrData | input | 8 | Register write data |
| hwEvt | input | 4 | Flag set pulses: ext0, tmr0, ext1, tmr1 |
| serRx | input | 1 | Serial receive-done level |
| serTx | input | 1 | Serial transmit-done level |
| insnDone | input | 1 | Instruction boundary strobe |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| takeIrq | output | 1 | One-cycle vector pulse |
| vecAddr | output | 16 | Handler address, valid with takeIrq |
| irqFlags | output | 4 | Current external/timer flags |
| inSvc | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
Every result is due one clock after the edge that samples its cause. `takeIrq` and `vecAddr` appear one cycle after the `insnDone` edge. The flag clear and the `inSvc` update land on that same edge. A return or a register write takes effect at the edge where it is sampled. The bench tags each expected take, or each expected silence, with the cycle number at which it is due. A monitor checks on the falling edge of that cycle and treats any `takeIrq` that no item predicted as a failure. State checks on `irqFlags` and `inSvc` are made on the falling edge after the causing edge.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NUM_SRC  = 5;
  localparam int NUM_FLAG = 4;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int NUM_LVL  = 2;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic             take;
    logic             takeHigh;
    logic [IDX_W-1:0] srcIdx;
    logic             retire;
  } irqStrobe_t;
endpackage

// File: rtl/irqPicker.sv
module irqPicker #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: index order is the polling order
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            insnDone,
  input  logic            retStrobe,
  input  logic [NSRC-1:0] reqVec,
  input  logic [NSRC-1:0] enMask,
  input  logic            enGlobal,
  input  logic [NSRC-1:0] prioMask,
  input  logic [1:0]      svcEff,
  output irqStrobe_t      strobe
);
  localparam int LVL_HI = 1;
  localparam int LVL_LO = 0;

  logic [NSRC-1:0]  eligible;
  logic [NSRC-1:0]  lvlReq [NUM_LVL];
  logic             lvlAny [NUM_LVL];
  logic [IDX_W-1:0] lvlIdx [NUM_LVL];

  assign eligible       = reqVec & enMask & {NSRC{enGlobal}};
  assign lvlReq[LVL_HI] = eligible & prioMask;
  assign lvlReq[LVL_LO] = eligible & ~prioMask;

  for (genvar l = 0; l < NUM_LVL; l++) begin : gLvl
    irqPicker #(.N(NSRC), .IDX_W(IDX_W)) uPick (
      .req (lvlReq[l]),
      .any (lvlAny[l]),
      .idx (lvlIdx[l])
    );
  end

  always_comb begin
    strobe        = '0;
    strobe.retire = retStrobe;
    if (insnDone && !svcEff[1] && lvlAny[LVL_HI]) begin
      strobe.take     = 1'b1;
      strobe.takeHigh = 1'b1;
      strobe.srcIdx   = lvlIdx[LVL_HI];
    end else if (insnDone && (svcEff == 2'b00) && lvlAny[LVL_LO]) begin
      strobe.take     = 1'b1;
      strobe.takeHigh = 1'b0;
      strobe.srcIdx   = lvlIdx[LVL_LO];
    end
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          NSRC       = NUM_SRC,
  parameter int          NFLAG      = NUM_FLAG,
  parameter int          GLOBAL_BIT = 7,
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter int          STRIDE_SH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [NFLAG-1:0]  hwEvt,
  input  logic              serRx,
  input  logic              serTx,
  input  irqStrobe_t        strobe,
  output logic [NSRC-1:0]   reqVec,
  output logic [NSRC-1:0]   enMask,
  output logic              enGlobal,
  output logic [NSRC-1:0]   prioMask,
  output logic [1:0]        svcEff,
  output logic [1:0]        inSvc,
  output logic [NFLAG-1:0]  irqFlags,
  output logic              takeIrq,
  output logic [ADDR_W-1:0] vecAddr
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask   <= '0;
      enGlobal <= 1'b0;
      prioMask <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) begin
        prioMask <= cfgWrData[NSRC-1:0];
      end else begin
        enMask   <= cfgWrData[NSRC-1:0];
        enGlobal <= cfgWrData[GLOBAL_BIT];
      end
    end
  end

  // Hardware-cleared flags for timer and external sources
  for (genvar g = 0; g < NFLAG; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)
        irqFlags[g] <= 1'b0;
      else if (hwEvt[g])
        irqFlags[g] <= 1'b1;
      else if (strobe.take && (strobe.srcIdx == IDX_W'(g)))
        irqFlags[g] <= 1'b0;
    end
  end

  assign reqVec = {serRx | serTx, irqFlags};

  // In-service levels, return applied before a new take
  always_comb begin
    svcEff = inSvc;
    if (strobe.retire) begin
      if (inSvc[1]) svcEff[1] = 1'b0;
      else          svcEff[0] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvc   <= 2'b00;
      takeIrq <= 1'b0;
      vecAddr <= '0;
    end else begin
      inSvc   <= svcEff | (strobe.take ? (strobe.takeHigh ? 2'b10 : 2'b01) : 2'b00);
      takeIrq <= strobe.take;
      if (strobe.take)
        vecAddr <= BASE_A + (ADDR_W'(strobe.srcIdx) << STRIDE_SH);
    end
  end
endmodule

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [7:0]  cfgWrData,
  input  logic [3:0]  hwEvt,
  input  logic        serRx,
  input  logic        serTx,
  input  logic        insnDone,
  input  logic        retStrobe,
  output logic        takeIrq,
  output logic [15:0] vecAddr,
  output logic [3:0]  irqFlags,
  output logic [1:0]  inSvc
);
  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] reqVec;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] prioMask;
  logic               enGlobal;
  logic [1:0]         svcEff;

  irqControl uCtl (
    .insnDone  (insnDone),
    .retStrobe (retStrobe),
    .reqVec    (reqVec),
    .enMask    (enMask),
    .enGlobal  (enGlobal),
    .prioMask  (prioMask),
    .svcEff    (svcEff),
    .strobe    (strobe)
  );

  irqDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .hwEvt     (hwEvt),
    .serRx     (serRx),
    .serTx     (serTx),
    .strobe    (strobe),
    .reqVec    (reqVec),
    .enMask    (enMask),
    .enGlobal  (enGlobal),
    .prioMask  (prioMask),
    .svcEff    (svcEff),
    .inSvc     (inSvc),
    .irqFlags  (irqFlags),
    .takeIrq   (takeIrq),
    .vecAddr   (vecAddr)
  );
endmodule

// File: rtl/irqCtrlChk.sv
module irqCtrlChk (
  input logic        clk,
  input logic        rstN,
  input logic        insnDone,
  input logic        retStrobe,
  input logic [3:0]  hwEvt,
  input logic        takeIrq,
  input logic [15:0] vecAddr,
  input logic [3:0]  irqFlags,
  input logic [1:0]  inSvc,
  input logic        enGlobal
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(insnDone)); // R3

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(enGlobal)); // R2

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vecAddr == 16'h0003 || vecAddr == 16'h000B || vecAddr == 16'h0013 ||
                 vecAddr == 16'h001B || vecAddr == 16'h0023)); // R9

  AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (!$past(inSvc[1]) || $past(retStrobe))); // R6

  AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && !inSvc[1]) |-> (($past(inSvc) == 2'b00) ||
                                ($past(retStrobe) && $past(inSvc) != 2'b11))); // R8

  AST_TMR0_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && vecAddr == 16'h000B && !$past(hwEvt[1])) |-> !irqFlags[1]); // R10

  AST_RET_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(retStrobe) && $past(inSvc) == 2'b11 && !takeIrq) |-> inSvc == 2'b01); // R11
endmodule

bind irqCtrl irqCtrlChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .insnDone  (insnDone),
  .retStrobe (retStrobe),
  .hwEvt     (hwEvt),
  .takeIrq   (takeIrq),
  .vecAddr   (vecAddr),
  .irqFlags  (irqFlags),
  .inSvc     (inSvc),
  .enGlobal  (enGlobal)
);

// File: tb/sim_irqCtrl.sv
`timescale 1ns/1ps
module sim_irqCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [3:0]  hwEvt = '0;
  logic        serRx = 1'b0;
  logic        serTx = 1'b0;
  logic        insnDone = 1'b0;
  logic        retStrobe = 1'b0;
  logic        takeIrq;
  logic [15:0] vecAddr;
  logic [3:0]  irqFlags;
  logic [1:0]  inSvc;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct packed {
    int          due;
    logic        take;
    logic [15:0] vec;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  always #4 clk = ~clk;

  irqCtrl u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .hwEvt(hwEvt), .serRx(serRx), .serTx(serTx), .insnDone(insnDone),
    .retStrobe(retStrobe), .takeIrq(takeIrq), .vecAddr(vecAddr),
    .irqFlags(irqFlags), .inSvc(inSvc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares due expectations and flags stray takes
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        expItem_t e;
        string    t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        nChecks++;
        if (takeIrq !== e.take || (e.take && vecAddr !== e.vec)) begin
          nFails++;
          $display("FAIL %s: take=%0b vec=%h, expected take=%0b vec=%h",
                   t, takeIrq, vecAddr, e.take, e.vec);
        end
      end else if (takeIrq) begin
        nChecks++;
        nFails++;
        $display("FAIL R3: unexpected take vec=%h, expected no take", vecAddr);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input bit sel, input logic [7:0] data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [3:0] m);
    hwEvt = m;
    @(negedge clk);
    hwEvt = '0;
  endtask

  task automatic step(input bit expTake, input logic [15:0] vec, input string tag);
    insnDone = 1'b1;
    expQ.push_back('{cyc + 1, expTake, vec});
    tagQ.push_back(tag);
    @(negedge clk);
    insnDone = 1'b0;
  endtask

  task automatic idleExpectNone(input string tag);
    expQ.push_back('{cyc + 1, 1'b0, 16'h0});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic doRet();
    retStrobe = 1'b1;
    @(negedge clk);
    retStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(takeIrq == 1'b0, "R1 takeIrq", takeIrq, 0);
    chk(inSvc == 2'b00, "R1 inSvc", inSvc, 0);
    chk(irqFlags == 4'h0, "R1 flags", irqFlags, 0);
    pulseEvt(4'b1000);
    chk(irqFlags == 4'b1000, "R10 tmr1 flag set", irqFlags, 4'b1000);
    step(1'b0, 16'h0, "R1 disabled after reset");
    // R2 gating
    writeCfg(1'b0, 8'h08);
    step(1'b0, 16'h0, "R2 own bit without global");
    writeCfg(1'b0, 8'h88);
    step(1'b1, 16'h001B, "R2 R9 timer1 vector");
    chk(irqFlags[3] == 1'b0, "R10 tmr1 cleared", irqFlags, 0);
    chk(inSvc == 2'b01, "R8 low level marked", inSvc, 1);
    doRet();
    chk(inSvc == 2'b00, "R11 low cleared", inSvc, 0);
    // R3 no evaluation without boundary strobe
    writeCfg(1'b0, 8'h9F);
    pulseEvt(4'b0001);
    idleExpectNone("R3 no boundary");
    idleExpectNone("R3 no boundary");
    step(1'b1, 16'h0003, "R3 R9 ext0 vector");
    doRet();
    // R4 polling order among low sources
    pulseEvt(4'b1110);
    step(1'b1, 16'h000B, "R4 tmr0 first");
    step(1'b0, 16'h0, "R8 low blocked by low");
    doRet();
    step(1'b1, 16'h0013, "R4 ext1 second");
    doRet();
    step(1'b1, 16'h001B, "R4 tmr1 third");
    doRet();
    chk(irqFlags == 4'h0, "R10 all cleared", irqFlags, 0);
    // R5 R6 R7 serial high
    writeCfg(1'b1, 8'hF0);
    serRx = 1'b1;
    pulseEvt(4'b0001);
    step(1'b1, 16'h0023, "R5 high serial beats ext0");
    chk(inSvc == 2'b10, "R8 high level marked", inSvc, 2);
    step(1'b0, 16'h0, "R6 high blocks all");
    doRet();
    chk(inSvc == 2'b00, "R11 high cleared", inSvc, 0);
    step(1'b1, 16'h0023, "R10 serial retriggers");
    doRet();
    serRx = 1'b0;
    step(1'b1, 16'h0003, "R5 low taken when high gone");
    chk(inSvc == 2'b01, "R8 low marked", inSvc, 1);
    serTx = 1'b1;
    step(1'b1, 16'h0023, "R7 high preempts low");
    chk(inSvc == 2'b11, "R7 both levels", inSvc, 3);
    doRet();
    chk(inSvc == 2'b01, "R11 high first", inSvc, 1);
    serTx = 1'b0;
    doRet();
    chk(inSvc == 2'b00, "R11 then low", inSvc, 0);
    // R12 priority layout
    writeCfg(1'b1, 8'h02);
    pulseEvt(4'b0011);
    step(1'b1, 16'h000B, "R12 tmr0 high over ext0");
    doRet();
    step(1'b1, 16'h0003, "R12 ext0 low after");
    doRet();
    // R2 global off
    writeCfg(1'b0, 8'h1F);
    pulseEvt(4'b0100);
    step(1'b0, 16'h0, "R2 global off");
    chk(irqFlags == 4'b0100, "R10 flag held", irqFlags, 4'b0100);
    writeCfg(1'b0, 8'h9F);
    step(1'b1, 16'h0013, "R2 global on");
    doRet();
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3 queue drained", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule